// File: doc/BRIEF.md
# Generic DMA Slave Transfer Engine

This block is the slave side of a request/acknowledge DMA handshake between an internal endpoint FIFO and an external DMA peripheral. It moves one 16-bit word per data strobe. A command pulse loads a 32-bit byte count and the transfer direction. While a transfer runs, the engine raises its request line. For each completed external strobe it pops a word from the FIFO (peripheral reads) or pushes one (peripheral writes). The transfer ends when the byte count runs out or when the peripheral signals end-of-transfer.

The external strobe pins (read strobe, write strobe, acknowledge) and the end-of-transfer pin are asynchronous inputs. Each passes through a two-flop synchronizer. A strobe counts on its deasserting edge. A 2-bit mode input chooses which pin acts as the read strobe and which as the write strobe. A separate bit sets the active level of each handshake pin. The count can be set to keep running without ending the transfer, so that only the external end-of-transfer stops it.

Top module: `gdma_slave_engine`

## Requirements
- R1: After synchronous reset: `busy`, `bus_oe`, `int_eot`, `ext_eot`, `fifo_pop` and `fifo_push` are 0, `bytes_left` is 0, and `dreq_pin` sits at its inactive level.
- R2: The active strobe depends on `strobe_mode`.
  - Mode 2'b00 (and 2'b11, treated the same): `dior_pin` is the read strobe and `diow_pin` is the write strobe.
  - Mode 2'b01: `dior_pin` reads and `dack_pin` writes.
  - Mode 2'b10: `dack_pin` is both strobes.
  - While `busy`, each deasserting edge of the strobe for the latched direction gives one `fifo_pop` pulse (direction 1, peripheral reads) or one `fifo_push` pulse (direction 0).
  - Strobes on other pins, or outside a transfer, move nothing.
- R3: Each pin has its own polarity bit: `pol_rd` for `dior_pin`, `pol_wr` for `diow_pin`, `pol_ack` for `dack_pin`, `pol_req` for `dreq_pin` and `pol_eot` for `eot_pin`. A value of 1 means active high and 0 means active low.
- R4: `bus_oe` is 0 until a command starts a transfer. It is 1 while busy in the read direction and 0 in the write direction or when idle.
- R5: `cmd_start` while idle loads `xfer_bytes` into `bytes_left`. Each moved word subtracts 2, modulo 2^32.
- R6: With `cnt_disable` = 0, the word moved while `bytes_left` <= 2 ends the transfer: `int_eot` is set and `busy` clears. A command with a count of 0 completes at once with `int_eot`.
- R7: With `cnt_disable` = 1, the count keeps decrementing and wraps through zero, and it never ends the transfer or sets `int_eot`.
- R8: `eot_pin` counts only while the selected strobe is active. The transfer then ends at that word's deasserting edge: `ext_eot` is set and `busy` clears. An end-of-transfer pulse with no strobe active is ignored.
- R9: When the word that exhausts the count also carries end-of-transfer, `int_eot` and `ext_eot` are set in the same cycle.
- R10: `dreq_pin` is active while busy with no strobe in progress. It goes inactive while a strobe is active, returns after each word, and is inactive when idle.
- R11: `cmd_start` while busy is ignored. A new command clears both completion flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle command pulse |
| cmd_dir_rd | input | 1 | 1: peripheral reads (FIFO pop), 0: peripheral writes (FIFO push) |
| xfer_bytes | input | CNT_W | Byte count loaded by the command |
| cnt_disable | input | 1 | Count never ends the transfer |
| strobe_mode | input | 2 | Strobe pin assignment |
| pol_rd | input | 1 | Read strobe pin polarity |
| pol_wr | input | 1 | Write strobe pin polarity |
| pol_ack | input | 1 | Acknowledge pin polarity |
| pol_req | input | 1 | Request pin polarity |
| pol_eot | input | 1 | End-of-transfer pin polarity |
| dior_pin | input | 1 | External read strobe pin |
| diow_pin | input | 1 | External write strobe pin |
| dack_pin | input | 1 | External acknowledge pin |
| eot_pin | input | 1 | External end-of-transfer pin |
| dreq_pin | output | 1 | DMA request to the peripheral |
| bus_oe | output | 1 | Data bus drive enable |
| fifo_pop | output | 1 | Pop one word from the FIFO |
| fifo_push | output | 1 | Push one word into the FIFO |
| busy | output | 1 | Transfer in progress |
| int_eot | output | 1 | Transfer ended by the count |
| ext_eot | output | 1 | Transfer ended by the external pin |
| bytes_left | output | CNT_W | Remaining byte count |

## Verification
Count exhaustion and external end-of-transfer can land on the same word. The bench provokes this by programming 4 bytes and asserting the end-of-transfer pin during the second strobe. It then expects both flags set together, the count at zero and exactly two FIFO pops. A second case runs with the count disabled: the count wraps below zero and only the pin ends the transfer. That case shows the two completion paths stay independent.

// File: rtl/gdma_pkg.sv
package gdma_pkg;
    localparam int CNT_W       = 32;
    localparam int WORD_BYTES  = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SMODE_SPLIT    = 2'b00,
        SMODE_ACK_WR   = 2'b01,
        SMODE_ACK_BOTH = 2'b10,
        SMODE_RSVD     = 2'b11
    } smode_e;

    typedef struct packed {
        logic eot;
        logic dack;
        logic diow;
        logic dior;
    } pins_t;

    typedef struct packed {
        logic eot;
        logic dack;
        logic wr;
        logic rd;
    } pol_t;

    localparam int PIN_W = $bits(pins_t);

    // Convert a pin level to "asserted" given its polarity bit (1 = active high)
    function automatic logic asserted(input logic raw, input logic pol);
        return pol ? raw : ~raw;
    endfunction
endpackage

// File: rtl/gdma_sync.sv
module gdma_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gdma_strobe_sel.sv
module gdma_strobe_sel
    import gdma_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       dir_rd,
    input  pins_t      pins,
    input  pol_t       pol,
    output logic       stb_act,
    output logic       eot_act
);
    logic rd_act, wr_act;

    always_comb begin
        case (smode_e'(mode))
            SMODE_ACK_WR: begin
                rd_act = asserted(pins.dior, pol.rd);
                wr_act = asserted(pins.dack, pol.dack);
            end
            SMODE_ACK_BOTH: begin
                rd_act = asserted(pins.dack, pol.dack);
                wr_act = asserted(pins.dack, pol.dack);
            end
            default: begin
                rd_act = asserted(pins.dior, pol.rd);
                wr_act = asserted(pins.diow, pol.wr);
            end
        endcase
        stb_act = dir_rd ? rd_act : wr_act;
    end

    assign eot_act = asserted(pins.eot, pol.eot);
endmodule

// File: rtl/gdma_byte_counter.sv
module gdma_byte_counter #(
    parameter int W    = 32,
    parameter int STEP = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         last
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - STEP_V;
    end

    assign last = (cnt <= STEP_V);
endmodule

// File: rtl/gdma_slave_engine.sv
module gdma_slave_engine
    import gdma_pkg::*;
#(
    parameter int CNT_W = gdma_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             cmd_dir_rd,
    input  logic [CNT_W-1:0] xfer_bytes,
    input  logic             cnt_disable,
    input  logic [1:0]       strobe_mode,
    input  logic             pol_rd,
    input  logic             pol_wr,
    input  logic             pol_ack,
    input  logic             pol_req,
    input  logic             pol_eot,
    input  logic             dior_pin,
    input  logic             diow_pin,
    input  logic             dack_pin,
    input  logic             eot_pin,
    output logic             dreq_pin,
    output logic             bus_oe,
    output logic             fifo_pop,
    output logic             fifo_push,
    output logic             busy,
    output logic             int_eot,
    output logic             ext_eot,
    output logic [CNT_W-1:0] bytes_left
);
    pins_t raw_pins, syn_pins;
    pol_t  pol;
    logic  stb_act, eot_act, cnt_last;
    logic  stb_prev, eot_seen, busy_q, dir_q, int_q, ext_q, pop_q, push_q;

    assign raw_pins = '{eot: eot_pin, dack: dack_pin, diow: diow_pin, dior: dior_pin};
    assign pol      = '{eot: pol_eot, dack: pol_ack, wr: pol_wr, rd: pol_rd};

    gdma_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_pins)
    );

    gdma_strobe_sel u_sel (
        .mode    (strobe_mode),
        .dir_rd  (dir_q),
        .pins    (syn_pins),
        .pol     (pol),
        .stb_act (stb_act),
        .eot_act (eot_act)
    );

    // A word moves on the deasserting edge of the selected strobe
    logic stb_done, word, start_ok, zero_load, hit_cnt, hit_eot;
    assign stb_done  = stb_prev & ~stb_act;
    assign word      = busy_q & stb_done;
    assign start_ok  = cmd_start & ~busy_q;
    assign zero_load = ~cnt_disable & (xfer_bytes == '0);
    assign hit_cnt   = word & ~cnt_disable & cnt_last;
    assign hit_eot   = word & eot_seen;

    gdma_byte_counter #(.W(CNT_W), .STEP(WORD_BYTES)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start_ok),
        .load_val (xfer_bytes),
        .dec      (word),
        .cnt      (bytes_left),
        .last     (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev <= 1'b0;
            eot_seen <= 1'b0;
            busy_q   <= 1'b0;
            dir_q    <= 1'b0;
            int_q    <= 1'b0;
            ext_q    <= 1'b0;
            pop_q    <= 1'b0;
            push_q   <= 1'b0;
        end else begin
            stb_prev <= stb_act;
            pop_q    <= word & dir_q;
            push_q   <= word & ~dir_q;
            if (start_ok) begin
                dir_q    <= cmd_dir_rd;
                busy_q   <= ~zero_load;
                int_q    <= zero_load;
                ext_q    <= 1'b0;
                eot_seen <= 1'b0;
            end else if (busy_q) begin
                if (stb_act && eot_act) eot_seen <= 1'b1;
                if (hit_cnt || hit_eot) begin
                    busy_q <= 1'b0;
                    int_q  <= hit_cnt;
                    ext_q  <= hit_eot;
                end
            end
        end
    end

    logic dreq_act;
    assign dreq_act  = busy_q & ~stb_act & ~stb_prev;
    assign dreq_pin  = pol_req ? dreq_act : ~dreq_act;
    assign bus_oe    = busy_q & dir_q;
    assign fifo_pop  = pop_q;
    assign fifo_push = push_q;
    assign busy      = busy_q;
    assign int_eot   = int_q;
    assign ext_eot   = ext_q;
endmodule

// File: rtl/gdma_slave_checker.sv
module gdma_slave_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_disable,
    input logic             pol_req,
    input logic             dreq_pin,
    input logic             bus_oe,
    input logic             fifo_pop,
    input logic             fifo_push,
    input logic             busy,
    input logic             int_eot,
    input logic             ext_eot,
    input logic [CNT_W-1:0] bytes_left
);
    AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !fifo_pop && !fifo_push);                              // R2
    AST_POP_PUSH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fifo_pop && fifo_push));                                        // R2
    AST_BUS_HIZ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_oe);                                               // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop || fifo_push) |-> bytes_left == $past(bytes_left) - CNT_W'(2)); // R5
    AST_FLAG_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($rose(int_eot) || $rose(ext_eot)) |-> !busy);                    // R6
    AST_NO_INT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        $rose(int_eot) |-> !$past(cnt_disable));                          // R7
    AST_DREQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> dreq_pin == !pol_req);                                  // R10
endmodule

bind gdma_slave_engine gdma_slave_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnt_disable (cnt_disable),
    .pol_req     (pol_req),
    .dreq_pin    (dreq_pin),
    .bus_oe      (bus_oe),
    .fifo_pop    (fifo_pop),
    .fifo_push   (fifo_push),
    .busy        (busy),
    .int_eot     (int_eot),
    .ext_eot     (ext_eot),
    .bytes_left  (bytes_left)
);

// File: tb/test_gdma_slave_engine.sv
module test_gdma_slave_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0, cmd_dir_rd = 1'b0, cnt_disable = 1'b0;
    logic [31:0] xfer_bytes = '0;
    logic [1:0]  strobe_mode = 2'b00;
    logic        pol_rd = 1'b1, pol_wr = 1'b1, pol_ack = 1'b1, pol_req = 1'b1, pol_eot = 1'b1;
    logic        dior = 1'b0, diow = 1'b0, dack = 1'b0, eot = 1'b0;
    logic        dreq_pin, bus_oe, fifo_pop, fifo_push, busy, int_eot, ext_eot;
    logic [31:0] bytes_left;

    int n_checks = 0, n_errors = 0, n_pop = 0, n_push = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gdma_slave_engine i_gdma_slave_engine (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_dir_rd(cmd_dir_rd),
        .xfer_bytes(xfer_bytes), .cnt_disable(cnt_disable), .strobe_mode(strobe_mode),
        .pol_rd(pol_rd), .pol_wr(pol_wr), .pol_ack(pol_ack), .pol_req(pol_req),
        .pol_eot(pol_eot), .dior_pin(dior), .diow_pin(diow), .dack_pin(dack),
        .eot_pin(eot), .dreq_pin(dreq_pin), .bus_oe(bus_oe), .fifo_pop(fifo_pop),
        .fifo_push(fifo_push), .busy(busy), .int_eot(int_eot), .ext_eot(ext_eot),
        .bytes_left(bytes_left)
    );

    always @(negedge clk) begin
        if (fifo_pop)  n_pop++;
        if (fifo_push) n_push++;
    end

    // mode, dir_rd, pol{eot,ack,req,wr,rd}, bytes, cnt_dis, words, eot_on_last,
    // exp_pop, exp_push, exp_int, exp_ext, exp_busy, exp_left
    typedef struct packed {
        logic [1:0]  mode;
        logic        dir_rd;
        logic [4:0]  pol;
        logic [31:0] bytes;
        logic        dis;
        logic [3:0]  words;
        logic        eot_last;
        logic [3:0]  exp_pop;
        logic [3:0]  exp_push;
        logic        exp_int;
        logic        exp_ext;
        logic        exp_busy;
        logic [31:0] exp_left;
    } vec_t;

    localparam vec_t VECS [8] = '{
        {2'b00, 1'b1, 5'b11111, 32'd6,  1'b0, 4'd3, 1'b0, 4'd3, 4'd0, 1'b1, 1'b0, 1'b0, 32'd0},
        {2'b00, 1'b0, 5'b00000, 32'd4,  1'b0, 4'd2, 1'b0, 4'd0, 4'd2, 1'b1, 1'b0, 1'b0, 32'd0},
        {2'b01, 1'b1, 5'b11111, 32'd8,  1'b0, 4'd2, 1'b0, 4'd2, 4'd0, 1'b0, 1'b0, 1'b1, 32'd4},
        {2'b01, 1'b0, 5'b10111, 32'd4,  1'b0, 4'd2, 1'b0, 4'd0, 4'd2, 1'b1, 1'b0, 1'b0, 32'd0},
        {2'b10, 1'b1, 5'b01111, 32'd10, 1'b0, 4'd2, 1'b1, 4'd2, 4'd0, 1'b0, 1'b1, 1'b0, 32'd6},
        {2'b10, 1'b0, 5'b11111, 32'd2,  1'b1, 4'd3, 1'b1, 4'd0, 4'd3, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFC},
        {2'b00, 1'b1, 5'b11010, 32'd4,  1'b0, 4'd2, 1'b1, 4'd2, 4'd0, 1'b1, 1'b1, 1'b0, 32'd0},
        {2'b11, 1'b0, 5'b11111, 32'd2,  1'b0, 4'd1, 1'b0, 4'd0, 4'd1, 1'b1, 1'b0, 1'b0, 32'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe pin per mode and direction (R2): 0 read-strobe pin, 1 write-strobe pin, 2 ack pin
    function automatic int pick_pin(input logic [1:0] mode, input logic dir_rd);
        if (mode == 2'b10) return 2;
        if (mode == 2'b01) return dir_rd ? 0 : 2;
        return dir_rd ? 0 : 1;
    endfunction

    function automatic logic pin_pol(input int pin);
        return (pin == 0) ? pol_rd : (pin == 1) ? pol_wr : pol_ack;
    endfunction

    task automatic idle_pins();
        dior = ~pol_rd; diow = ~pol_wr; dack = ~pol_ack; eot = ~pol_eot;
    endtask

    task automatic set_pin(input int pin, input logic val);
        case (pin)
            0:       dior = val;
            1:       diow = val;
            default: dack = val;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_pins();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        n_pop = 0; n_push = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic strobe(input int pin, input logic with_eot, input logic look_req);
        @(negedge clk);
        set_pin(pin, pin_pol(pin));
        if (with_eot) eot = pol_eot;
        repeat (5) @(negedge clk);
        if (look_req) chk("R10 request drops during strobe", {31'd0, dreq_pin}, {31'd0, ~pol_req});
        set_pin(pin, ~pin_pol(pin));
        eot = ~pol_eot;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        vec_t t;
        int   pin;

        // Reset state (R1) and bus idle before any command (R4)
        cmd_dir_rd = 1'b1;
        do_reset();
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        chk("R1 request inactive after reset", {31'd0, dreq_pin}, 32'd0);
        chk("R1 flags after reset", {30'd0, int_eot, ext_eot}, 32'd0);
        chk("R1 count after reset", bytes_left, 32'd0);
        chk("R4 bus idle before command", {31'd0, bus_oe}, 32'd0);

        // Strobe with no command moves nothing (R2)
        strobe(0, 1'b0, 1'b0);
        chk("R2 no pop without command", n_pop, 32'd0);
        chk("R4 bus still idle", {31'd0, bus_oe}, 32'd0);

        // Table of vectors
        for (int v = 0; v < 8; v++) begin
            t = VECS[v];
            strobe_mode = t.mode; cmd_dir_rd = t.dir_rd;
            {pol_eot, pol_ack, pol_req, pol_wr, pol_rd} = t.pol;
            xfer_bytes = t.bytes; cnt_disable = t.dis;
            do_reset();
            pulse_start();
            repeat (3) @(negedge clk);
            chk("R10 R3 request active after command", {31'd0, dreq_pin}, {31'd0, pol_req});
            chk("R4 bus drive follows direction", {31'd0, bus_oe}, {31'd0, t.dir_rd});
            pin = pick_pin(t.mode, t.dir_rd);
            for (int w = 0; w < int'(t.words); w++)
                strobe(pin, t.eot_last && (w == int'(t.words) - 1), w == 0);
            chk("R2 R3 pops", n_pop, {28'd0, t.exp_pop});
            chk("R2 R3 pushes", n_push, {28'd0, t.exp_push});
            chk("R6 R7 R9 count completion flag", {31'd0, int_eot}, {31'd0, t.exp_int});
            chk("R8 R9 external completion flag", {31'd0, ext_eot}, {31'd0, t.exp_ext});
            chk("R6 R8 busy at end", {31'd0, busy}, {31'd0, t.exp_busy});
            chk("R5 R7 remaining count", bytes_left, t.exp_left);
        end

        // Zero count with counting on completes at once (R6); with counting off it runs (R7)
        strobe_mode = 2'b00; cmd_dir_rd = 1'b1; cnt_disable = 1'b0; xfer_bytes = 32'd0;
        {pol_eot, pol_ack, pol_req, pol_wr, pol_rd} = 5'b11111;
        do_reset();
        pulse_start();
        @(negedge clk);
        chk("R6 zero count not busy", {31'd0, busy}, 32'd0);
        chk("R6 zero count flag", {31'd0, int_eot}, 32'd1);
        cnt_disable = 1'b1;
        do_reset();
        pulse_start();
        strobe(0, 1'b0, 1'b0);
        chk("R7 disabled count keeps running", {31'd0, busy}, 32'd1);
        chk("R7 count wraps below zero", bytes_left, 32'hFFFF_FFFE);

        // Command while busy ignored, stray end-of-transfer ignored, flags cleared (R11, R8)
        cnt_disable = 1'b0; xfer_bytes = 32'd8;
        do_reset();
        pulse_start();
        strobe(0, 1'b0, 1'b0);
        chk("R5 first word", bytes_left, 32'd6);
        xfer_bytes = 32'd100;
        pulse_start();
        repeat (3) @(negedge clk);
        chk("R11 command while busy ignored", bytes_left, 32'd6);
        @(negedge clk); eot = pol_eot;
        repeat (6) @(negedge clk); eot = ~pol_eot;
        repeat (6) @(negedge clk);
        chk("R8 stray end pulse keeps busy", {31'd0, busy}, 32'd1);
        chk("R8 stray end pulse no flag", {31'd0, ext_eot}, 32'd0);
        strobe(0, 1'b0, 1'b0);
        strobe(0, 1'b0, 1'b0);
        strobe(0, 1'b0, 1'b0);
        chk("R6 count end", {31'd0, int_eot}, 32'd1);
        chk("R2 pops total", n_pop, 32'd4);
        xfer_bytes = 32'd4;
        pulse_start();
        @(negedge clk);
        chk("R11 new command clears flag", {31'd0, int_eot}, 32'd0);

        // Wrong pin in mode 01 write direction moves nothing (R2)
        strobe_mode = 2'b01; cmd_dir_rd = 1'b0;
        do_reset();
        pulse_start();
        strobe(1, 1'b0, 1'b0);
        chk("R2 write strobe pin ignored in mode 01", n_push, 32'd0);
        chk("R2 count unchanged", bytes_left, 32'd4);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule